// File: doc/BRIEF.md
# Reference Clock Period Calculator

This block turns a reference clock period into the output periods of three PLLs (IO, ARM, DDR) and of two gated UART reference clocks. Every value is a period, not a frequency, so a PLL multiplier becomes an integer division of the input period, and a clock divider becomes a multiplication of the selected PLL period. A period of 0 means the clock is off.

A new calculation starts after reset is released, when the owner of the control words pulses `cfg_wr_i` after changing one of them, and whenever `ref_period_i` differs from the value used in the previous calculation. The inputs are captured when the calculation starts. Three sequential dividers, one per PLL, then run side by side for one cycle per quotient bit. The five results are published together with a one-cycle `done_o` pulse, so a consumer never sees a mix of old and new values.

Top module: `ref_period_calc`

## Requirements
- R1: With bypass (bit 4), reset (bit 0) and power-down (bit 1) all clear in a PLL control word, that PLL's period is the input period divided by the multiplier field in bits 18:12, rounded down.
- R2: Forced bypass (bit 4) makes the PLL period equal the input period, even when reset, power-down or a zero multiplier is also present.
- R3: Without bypass, a set reset bit (bit 0) or power-down bit (bit 1) makes the PLL period 0.
- R4: Without bypass, reset or power-down, a multiplier field of 0 gives a PLL period of 0.
- R5: The UART source field (bits 5:4 of the UART control word) selects the IO PLL for values 0 and 1, the ARM PLL for 2 and the DDR PLL for 3; both UART outputs use the same source.
- R6: UART output 0 is 0 while enable bit 0 is clear, and UART output 1 is 0 while enable bit 1 is clear.
- R7: An enabled UART period is the selected PLL period times the divider field (bits 13:8), a divider of 0 acting as 1; a product above 2^32-1 saturates to 32'hFFFF_FFFF.
- R8: While `rst_ni` is low every output is 0 and `done_o` is low, also when reset arrives mid-calculation; after release a calculation runs without any write.
- R9: A `cfg_wr_i` pulse or a change of `ref_period_i` starts a calculation; all five outputs change only in the cycle `done_o` is high, `done_o` lasts one cycle, and a control word changed without a pulse leaves the outputs untouched.
- R10: A `cfg_wr_i` pulse that arrives during a calculation is kept, and a second calculation with the then-current inputs follows the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_period_i | input | 32 | Reference clock period |
| cfg_wr_i | input | 1 | One-cycle pulse: a control word was written |
| io_pll_ctrl_i | input | 32 | IO PLL control word |
| arm_pll_ctrl_i | input | 32 | ARM PLL control word |
| ddr_pll_ctrl_i | input | 32 | DDR PLL control word |
| uart_ctrl_i | input | 32 | UART clock control word |
| io_period_o | output | 32 | IO PLL output period |
| arm_period_o | output | 32 | ARM PLL output period |
| ddr_period_o | output | 32 | DDR PLL output period |
| uart0_period_o | output | 32 | UART 0 reference period |
| uart1_period_o | output | 32 | UART 1 reference period |
| done_o | output | 1 | One-cycle pulse: all five outputs were updated |

## Verification
The vector table pairs each PLL state (dividing with an exact and an inexact quotient, bypassed with reset or power-down also set, held in reset, powered down, zero multiplier) with a different UART source, divider and enable pair, so a wrong bit position, a swapped mux leg or a wrong priority shows up as a wrong number. A reference period of all ones combined with a divider of 2 tells saturation apart from wrap-around. Directed runs then separate the three triggers (write pulse, reference change, reset release) from a silent control change, and a second pulse during a busy calculation shows whether pending writes are lost.

// File: rtl/period_calc_pkg.sv
package period_calc_pkg;

    localparam int NUM_PLL  = 3;
    localparam int NUM_UART = 2;

    // PLL control word fields
    localparam int PLL_RST_BIT   = 0;
    localparam int PLL_PWRDN_BIT = 1;
    localparam int PLL_BYP_BIT   = 4;
    localparam int PLL_MULT_LSB  = 12;
    localparam int PLL_MULT_W    = 7;

    // UART clock control word fields
    localparam int UART_EN_LSB  = 0;
    localparam int UART_SEL_LSB = 4;
    localparam int UART_SEL_W   = 2;
    localparam int UART_DIV_LSB = 8;
    localparam int UART_DIV_W   = 6;

    typedef enum logic [1:0] {
        PLL_IO  = 2'd0,
        PLL_ARM = 2'd1,
        PLL_DDR = 2'd2
    } pll_id_e;

    typedef enum logic [1:0] {
        CALC_IDLE = 2'd0,
        CALC_LOAD = 2'd1,
        CALC_RUN  = 2'd2
    } calc_state_e;

    typedef enum logic [1:0] {
        PM_BYPASS = 2'd0,
        PM_OFF    = 2'd1,
        PM_DIVIDE = 2'd2
    } pll_mode_e;

endpackage

// File: rtl/pll_period_unit.sv
module pll_period_unit
    import period_calc_pkg::*;
#(
    parameter int W  = 32,
    parameter int MW = PLL_MULT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          launch_i,
    input  logic [W-1:0]  ref_i,
    input  logic          bypass_i,
    input  logic          off_i,
    input  logic [MW-1:0] mult_i,
    output logic [W-1:0]  period_o,
    output logic          done_o
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        pll_mode_e     mode;
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [MW-1:0] rem;
        logic [MW-1:0] div;
        logic [W-1:0]  quo;
        logic [W-1:0]  period;
    } unit_state_t;

    unit_state_t s_d, s_q;

    logic [MW:0]  shifted;
    logic [MW:0]  trial;
    logic         borrow;
    logic [W-1:0] quo_next;

    always_comb begin
        shifted  = {s_q.rem, s_q.quo[W-1]};
        trial    = shifted - {1'b0, s_q.div};
        borrow   = trial[MW];
        quo_next = {s_q.quo[W-2:0], ~borrow};

        s_d      = s_q;
        s_d.done = 1'b0;

        if (launch_i) begin
            // bypass outranks every other control bit
            if (bypass_i) begin
                s_d.mode = PM_BYPASS;
            end else if (off_i || (mult_i == '0)) begin
                s_d.mode = PM_OFF;
            end else begin
                s_d.mode = PM_DIVIDE;
            end
            s_d.quo    = ref_i;
            s_d.rem    = '0;
            s_d.div    = mult_i;
            s_d.cnt    = CW'(W);
            s_d.run    = 1'b1;
            s_d.period = bypass_i ? ref_i : '0;
        end else if (s_q.run) begin
            s_d.rem = borrow ? shifted[MW-1:0] : trial[MW-1:0];
            s_d.quo = quo_next;
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
                if (s_q.mode == PM_DIVIDE) begin
                    s_d.period = quo_next;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{mode: PM_OFF, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign period_o = s_q.period;
    assign done_o   = s_q.done;

endmodule

// File: rtl/uart_period_sel.sv
module uart_period_sel
    import period_calc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                  enable_i,
    input  logic [UART_SEL_W-1:0] src_i,
    input  logic [UART_DIV_W-1:0] div_i,
    input  logic [W-1:0]          io_i,
    input  logic [W-1:0]          arm_i,
    input  logic [W-1:0]          ddr_i,
    output logic [W-1:0]          period_o
);

    localparam int PW = W + UART_DIV_W;

    logic [W-1:0]          src_period;
    logic [UART_DIV_W-1:0] factor;
    logic [PW-1:0]         product;

    always_comb begin
        unique case (src_i)
            2'd2:    src_period = arm_i;
            2'd3:    src_period = ddr_i;
            default: src_period = io_i;   // codes 0 and 1
        endcase

        factor  = (div_i == '0) ? UART_DIV_W'(1) : div_i;
        product = PW'(src_period) * PW'(factor);

        if (!enable_i) begin
            period_o = '0;
        end else if (product[PW-1:W] != '0) begin
            period_o = '1;
        end else begin
            period_o = product[W-1:0];
        end
    end

endmodule

// File: rtl/ref_period_calc.sv
module ref_period_calc
    import period_calc_pkg::*;
#(
    parameter int W      = 32,
    parameter int CTRL_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [W-1:0]      ref_period_i,
    input  logic              cfg_wr_i,
    input  logic [CTRL_W-1:0] io_pll_ctrl_i,
    input  logic [CTRL_W-1:0] arm_pll_ctrl_i,
    input  logic [CTRL_W-1:0] ddr_pll_ctrl_i,
    input  logic [CTRL_W-1:0] uart_ctrl_i,
    output logic [W-1:0]      io_period_o,
    output logic [W-1:0]      arm_period_o,
    output logic [W-1:0]      ddr_period_o,
    output logic [W-1:0]      uart0_period_o,
    output logic [W-1:0]      uart1_period_o,
    output logic              done_o
);

    typedef struct packed {
        calc_state_e                    state;
        logic                           pending;
        logic [W-1:0]                   snap_ref;
        logic [NUM_PLL-1:0][CTRL_W-1:0] snap_pll;
        logic [CTRL_W-1:0]              snap_uart;
        logic [NUM_PLL-1:0][W-1:0]      pll_out;
        logic [NUM_UART-1:0][W-1:0]     uart_out;
        logic                           done;
    } calc_state_t;

    calc_state_t s_d, s_q;

    logic                           launch;
    logic                           trigger;
    logic [W-1:0]                   snap_ref;
    logic [NUM_PLL-1:0][CTRL_W-1:0] snap_pll;
    logic [CTRL_W-1:0]              snap_uart;
    logic [NUM_PLL-1:0][W-1:0]      pll_period;
    logic [NUM_PLL-1:0]             pll_done;
    logic [NUM_UART-1:0][W-1:0]     uart_period;
    logic [NUM_PLL-1:0][W-1:0]      pll_res;
    logic [NUM_UART-1:0][W-1:0]     uart_res;
    logic                           unused_uart_bits;

    assign snap_ref  = s_q.snap_ref;
    assign snap_pll  = s_q.snap_pll;
    assign snap_uart = s_q.snap_uart;
    assign launch    = (s_q.state == CALC_LOAD);
    assign trigger   = s_q.pending || cfg_wr_i || (ref_period_i != s_q.snap_ref);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            CALC_IDLE: begin
                if (trigger) begin
                    s_d.snap_ref          = ref_period_i;
                    s_d.snap_pll[PLL_IO]  = io_pll_ctrl_i;
                    s_d.snap_pll[PLL_ARM] = arm_pll_ctrl_i;
                    s_d.snap_pll[PLL_DDR] = ddr_pll_ctrl_i;
                    s_d.snap_uart         = uart_ctrl_i;
                    s_d.pending           = 1'b0;
                    s_d.state             = CALC_LOAD;
                end
            end
            CALC_LOAD: begin
                s_d.pending = s_q.pending || cfg_wr_i;
                s_d.state   = CALC_RUN;
            end
            CALC_RUN: begin
                s_d.pending = s_q.pending || cfg_wr_i;
                if (&pll_done) begin
                    s_d.pll_out  = pll_period;
                    s_d.uart_out = uart_period;
                    s_d.done     = 1'b1;
                    s_d.state    = CALC_IDLE;
                end
            end
            default: s_d.state = CALC_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: CALC_IDLE, pending: 1'b1, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
        logic unused_pll_bits;
        assign unused_pll_bits = ^{snap_pll[i][CTRL_W-1:PLL_MULT_LSB+PLL_MULT_W],
                                   snap_pll[i][PLL_MULT_LSB-1:PLL_BYP_BIT+1],
                                   snap_pll[i][PLL_BYP_BIT-1:PLL_PWRDN_BIT+1]};

        pll_period_unit #(
            .W  (W),
            .MW (PLL_MULT_W)
        ) u_pll (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .launch_i (launch),
            .ref_i    (snap_ref),
            .bypass_i (snap_pll[i][PLL_BYP_BIT]),
            .off_i    (snap_pll[i][PLL_RST_BIT] | snap_pll[i][PLL_PWRDN_BIT]),
            .mult_i   (snap_pll[i][PLL_MULT_LSB +: PLL_MULT_W]),
            .period_o (pll_period[i]),
            .done_o   (pll_done[i])
        );
    end

    for (genvar c = 0; c < NUM_UART; c++) begin : g_uart
        uart_period_sel #(
            .W (W)
        ) u_sel (
            .enable_i (snap_uart[UART_EN_LSB + c]),
            .src_i    (snap_uart[UART_SEL_LSB +: UART_SEL_W]),
            .div_i    (snap_uart[UART_DIV_LSB +: UART_DIV_W]),
            .io_i     (pll_period[PLL_IO]),
            .arm_i    (pll_period[PLL_ARM]),
            .ddr_i    (pll_period[PLL_DDR]),
            .period_o (uart_period[c])
        );
    end

    assign unused_uart_bits = ^{snap_uart[CTRL_W-1:UART_DIV_LSB+UART_DIV_W],
                                snap_uart[UART_DIV_LSB-1:UART_SEL_LSB+UART_SEL_W],
                                snap_uart[UART_SEL_LSB-1:UART_EN_LSB+NUM_UART]};

    assign pll_res        = s_q.pll_out;
    assign uart_res       = s_q.uart_out;
    assign io_period_o    = pll_res[PLL_IO];
    assign arm_period_o   = pll_res[PLL_ARM];
    assign ddr_period_o   = pll_res[PLL_DDR];
    assign uart0_period_o = uart_res[0];
    assign uart1_period_o = uart_res[1];
    assign done_o         = s_q.done;

endmodule

// File: rtl/ref_period_calc_checker.sv
module ref_period_calc_checker
    import period_calc_pkg::*;
#(
    parameter int W      = 32,
    parameter int CTRL_W = 32
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic                           done_i,
    input logic [NUM_PLL-1:0][W-1:0]      pll_period_i,
    input logic [NUM_UART-1:0][W-1:0]     uart_period_i,
    input logic [W-1:0]                   snap_ref_i,
    input logic [NUM_PLL-1:0][CTRL_W-1:0] snap_pll_i,
    input logic [CTRL_W-1:0]              snap_uart_i
);

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll_chk
        logic                  byp, off;
        logic [PLL_MULT_W-1:0] mult;
        assign byp  = snap_pll_i[i][PLL_BYP_BIT];
        assign off  = snap_pll_i[i][PLL_RST_BIT] | snap_pll_i[i][PLL_PWRDN_BIT];
        assign mult = snap_pll_i[i][PLL_MULT_LSB +: PLL_MULT_W];

        p_divide_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !byp && !off && (mult != '0))
            |-> (pll_period_i[i] == snap_ref_i / W'(mult)));

        p_bypass_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && byp) |-> (pll_period_i[i] == snap_ref_i));

        p_off_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !byp && off) |-> (pll_period_i[i] == '0));

        p_zero_mult_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !byp && !off && (mult == '0)) |-> (pll_period_i[i] == '0));
    end

    for (genvar c = 0; c < NUM_UART; c++) begin : g_uart_chk
        p_gate_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && !snap_uart_i[UART_EN_LSB + c]) |-> (uart_period_i[c] == '0));
    end

    p_hold_between_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |-> ($stable(pll_period_i) && $stable(uart_period_i)));

    p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

endmodule

bind ref_period_calc ref_period_calc_checker #(
    .W      (W),
    .CTRL_W (CTRL_W)
) u_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_i        (done_o),
    .pll_period_i  (pll_res),
    .uart_period_i (uart_res),
    .snap_ref_i    (snap_ref),
    .snap_pll_i    (snap_pll),
    .snap_uart_i   (snap_uart)
);

// File: tb/ref_period_calc_test.sv
`timescale 1ns/1ps
module ref_period_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ref_p = '0;
    logic        wr = 1'b0;
    logic [31:0] io_c = '0, arm_c = '0, ddr_c = '0, uart_c = '0;
    logic [31:0] io_p, arm_p, ddr_p, u0_p, u1_p;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    ref_period_calc uut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .ref_period_i   (ref_p),
        .cfg_wr_i       (wr),
        .io_pll_ctrl_i  (io_c),
        .arm_pll_ctrl_i (arm_c),
        .ddr_pll_ctrl_i (ddr_c),
        .uart_ctrl_i    (uart_c),
        .io_period_o    (io_p),
        .arm_period_o   (arm_p),
        .ddr_period_o   (ddr_p),
        .uart0_period_o (u0_p),
        .uart1_period_o (u1_p),
        .done_o         (done)
    );

    typedef struct packed {
        logic [31:0] ref_v;
        logic [31:0] io_v, arm_v, ddr_v, uart_v;
        logic [31:0] e_io, e_arm, e_ddr, e_u0, e_u1;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // R1 exact divides, R5 source 0 -> IO, R7 divider 3
        '{32'd1000, 32'h0000A000, 32'h00014000, 32'h00028000, 32'h00000303,
          32'd100, 32'd50, 32'd25, 32'd300, 32'd300},
        // R2 bypass+reset, R3 reset / power-down, R5 source 2, R7 divider 0, R6 en1 off
        '{32'd1000, 32'h0000A001, 32'h00014011, 32'h00028002, 32'h00000021,
          32'd0, 32'd1000, 32'd0, 32'd1000, 32'd0},
        // R4 zero multiplier, R1 inexact quotient, R5 source 3, R7 divider 63, R6 en0 off
        '{32'd7000, 32'h00000000, 32'h00007000, 32'h00003000, 32'h00003F32,
          32'd0, 32'd1000, 32'd2333, 32'd0, 32'd146979},
        // R1 multiplier 127, R5 source 1 -> IO, R7 divider 5
        '{32'd600, 32'h00006000, 32'h0003C000, 32'h0007F000, 32'h00000513,
          32'd100, 32'd10, 32'd4, 32'd500, 32'd500},
        // R7 saturation, R2 bypass of full period
        '{32'hFFFFFFFF, 32'h00002000, 32'h00014010, 32'h00001000, 32'h00000223,
          32'h7FFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        // R2 bypass with power-down and zero multiplier, R3 both off bits, R5 source 3
        '{32'd123, 32'h00001000, 32'h00000003, 32'h00000012, 32'h00000131,
          32'd123, 32'd0, 32'd123, 32'd123, 32'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d (0x%08h) expected=%0d (0x%08h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic wait_done(input string req);
        bit got = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done === 1'b1) begin
                got = 1'b1;
                break;
            end
        end
        check(req, "done pulse seen", 32'(got), 32'd1);
    endtask

    task automatic pulse_write();
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic check_all(input string req, input vec_t v);
        check(req, "io period",    io_p,  v.e_io);
        check(req, "arm period",   arm_p, v.e_arm);
        check(req, "ddr period",   ddr_p, v.e_ddr);
        check(req, "uart0 period", u0_p,  v.e_u0);
        check(req, "uart1 period", u1_p,  v.e_u1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stimulus
        vec_t v;
        int   seen;
        ref_p  = VECS[0].ref_v;
        io_c   = VECS[0].io_v;
        arm_c  = VECS[0].arm_v;
        ddr_c  = VECS[0].ddr_v;
        uart_c = VECS[0].uart_v;
        repeat (3) @(negedge clk);

        // R8: reset state
        check("R8", "done in reset", 32'(done), 32'd0);
        check("R8", "uart0 in reset", u0_p, 32'd0);
        check("R8", "io in reset", io_p, 32'd0);

        // R8: calculation after release without any write
        rst_n = 1'b1;
        wait_done("R8");
        check_all("R8", VECS[0]);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v      = VECS[i];
            ref_p  = v.ref_v;
            io_c   = v.io_v;
            arm_c  = v.arm_v;
            ddr_c  = v.ddr_v;
            uart_c = v.uart_v;
            pulse_write();
            wait_done("R1");
            check_all($sformatf("R1..R7 vec%0d", i), v);
        end

        // R9: a one-cycle done pulse
        @(negedge clk);
        check("R9", "done width", 32'(done), 32'd0);

        // R9: reference change alone triggers (controls from last vector)
        ref_p = 32'd2000;
        wait_done("R9");
        check("R9", "io after ref change",    io_p,  32'd2000);
        check("R9", "arm after ref change",   arm_p, 32'd0);
        check("R9", "ddr after ref change",   ddr_p, 32'd2000);
        check("R9", "uart0 after ref change", u0_p,  32'd2000);
        check("R9", "uart1 after ref change", u1_p,  32'd0);

        // R9: control change without a write pulse is ignored
        uart_c = 32'h00000303;
        seen = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (done === 1'b1) seen++;
        end
        check("R9", "done without write", 32'(seen), 32'd0);
        check("R9", "uart0 without write", u0_p, 32'd2000);
        check("R9", "uart1 without write", u1_p, 32'd0);

        // R10: a second write during a busy calculation is kept
        pulse_write();
        repeat (5) @(negedge clk);
        uart_c = 32'h00000203;
        pulse_write();
        wait_done("R10");
        check("R10", "uart0 first result",  u0_p, 32'd6000);
        check("R10", "uart1 first result",  u1_p, 32'd6000);
        wait_done("R10");
        check("R10", "uart0 second result", u0_p, 32'd4000);
        check("R10", "uart1 second result", u1_p, 32'd4000);

        // R8: reset in the middle of a calculation
        pulse_write();
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", "done mid reset",  32'(done), 32'd0);
        check("R8", "uart0 mid reset", u0_p, 32'd0);
        check("R8", "ddr mid reset",   ddr_p, 32'd0);
        rst_n = 1'b1;
        wait_done("R8");
        check("R8", "uart0 after reset", u0_p, 32'd4000);
        check("R8", "io after reset",    io_p, 32'd2000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule